// File: doc/BRIEF.md
# Banked Register File Decoder

This block is the data-memory front end of a small microcontroller core. The core presents a 7-bit direct file offset and a single bank bit. Together they form an 8-bit register address, which the block sorts into one of four regions: special-function registers, general-purpose static RAM, a shared window, or a hole. Special-function accesses pass straight through to an external register block. General-purpose accesses land in a 128-byte RAM held inside this block. Holes return zero.

The top of bank 1 (F0h–FFh) is an alias of the top of bank 0 (70h–7Fh). Code can reach these 16 bytes without changing the bank bit, so both addresses use the same storage. RAM writes take effect on the rising clock edge. All reads are combinational from the current address.

Top module: `regbank_decode`

## Requirements
- R1: The full register address is the bank bit as bit 7 above the 7-bit offset as bits 6:0. This address appears on `sfr_addr`.
- R2: An offset in 00h–1Fh, in either bank, raises `sfr_sel`, and `core_rdata` then equals `sfr_rdata`.
- R3: `sfr_we` is high only when `sfr_sel` and `core_we` are both high. An SFR write leaves every RAM byte unchanged.
- R4: Bank-0 addresses 20h–7Fh are RAM bytes that return the last value written to them.
- R5: Bank-1 addresses A0h–BFh are RAM bytes of their own, separate from every bank-0 byte.
- R6: Bank-1 addresses F0h–FFh use the same bytes as bank-0 addresses 70h–7Fh (the same low 4 bits). A write through either address is read back through the other.
- R7: Bank-1 addresses C0h–EFh read as 00h and do not raise `sfr_sel`.
- R8: A write to C0h–EFh is discarded and changes no RAM byte.
- R9: A RAM write is committed at the rising clock edge while `core_we` is high. Before that edge, a read returns the old value; after it, the new one.
- R10: After reset, every RAM byte reads as 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; RAM writes on its rising edge |
| rst_n | input | 1 | Active-low reset; clears the RAM |
| core_addr | input | 7 | Direct file offset from the core |
| core_bank | input | 1 | Bank select: 0 = bank 0, 1 = bank 1 |
| core_wdata | input | 8 | Write data from the core |
| core_we | input | 1 | Write enable from the core |
| core_rdata | output | 8 | Read data to the core |
| sfr_sel | output | 1 | High when the address decodes to a special-function register |
| sfr_addr | output | 8 | Full 8-bit register address |
| sfr_wdata | output | 8 | Write data forwarded to the SFR block |
| sfr_we | output | 1 | Write strobe to the SFR block |
| sfr_rdata | input | 8 | Read value returned by the SFR block |

## Verification
The hardest case to reach from the ports is a stray write: a write to a hole or an SFR address that quietly corrupts some other RAM byte. No single read-back would catch it. To expose it, the stimulus first writes a distinct value to every implemented byte, derived from its own address. It then writes FFh to every hole address and re-reads the whole map. The alias is driven in both directions against this same known pattern. Write timing is checked by sampling the read port just before and just after the committing edge.

// File: rtl/regbank_pkg.sv
package regbank_pkg;

    typedef enum logic [1:0] {
        RGN_SFR  = 2'd0,
        RGN_GPR  = 2'd1,
        RGN_NONE = 2'd2
    } region_e;

endpackage

// File: rtl/regbank_addr_map.sv
module regbank_addr_map
    import regbank_pkg::*;
#(
    parameter int OFS_W    = 7,
    parameter int SFR_SPAN = 32,
    parameter int B1_GPR   = 32,
    parameter int SHARED   = 16,
    parameter int IDX_W    = 7
) (
    input  logic [OFS_W-1:0] offset,
    input  logic             bank,
    output region_e          region,
    output logic [IDX_W-1:0] ram_idx,
    output logic [OFS_W:0]   full_addr
);
    localparam int OFS_SPAN = 2 ** OFS_W;
    localparam int B0_GPR   = OFS_SPAN - SFR_SPAN;
    localparam int B1_HI    = SFR_SPAN + B1_GPR;
    localparam int ALIAS_LO = OFS_SPAN - SHARED;

    int ofs;

    always_comb begin
        ofs       = int'(offset);
        full_addr = {bank, offset};
        region    = RGN_NONE;
        ram_idx   = '0;
        if (ofs < SFR_SPAN) begin
            region = RGN_SFR;
        end else if (!bank) begin
            region  = RGN_GPR;
            ram_idx = IDX_W'(ofs - SFR_SPAN);
        end else if (ofs < B1_HI) begin
            region  = RGN_GPR;
            ram_idx = IDX_W'(B0_GPR + ofs - SFR_SPAN);
        end else if (ofs >= ALIAS_LO) begin
            region  = RGN_GPR;
            ram_idx = IDX_W'(ofs - SFR_SPAN);
        end
    end

    // bank-1 top window must land on the bank-0 byte with the same offset
    always_comb begin
        if (bank === 1'b1 && int'(offset) >= ALIAS_LO) begin
            p_alias_shared_r6: assert (region == RGN_GPR && ram_idx == IDX_W'(int'(offset) - SFR_SPAN));
        end
    end

endmodule

// File: rtl/regbank_gpr_ram.sv
module regbank_gpr_ram #(
    parameter int DEPTH  = 128,
    parameter int DATA_W = 8,
    parameter int IDX_W  = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    typedef struct packed {
        logic [DEPTH-1:0][DATA_W-1:0] mem;
    } ram_s;

    ram_s ram_d, ram_q;

    always_comb begin
        ram_d = ram_q;
        if (we && int'(idx) < DEPTH) begin
            ram_d.mem[idx] = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ram_q <= '0;
        end else begin
            ram_q <= ram_d;
        end
    end

    assign rdata = (int'(idx) < DEPTH) ? ram_q.mem[idx] : '0;

    p_write_lands_r9: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> ram_q.mem[$past(idx)] == $past(wdata));

endmodule

// File: rtl/regbank_decode.sv
module regbank_decode
    import regbank_pkg::*;
#(
    parameter int OFS_W    = 7,
    parameter int DATA_W   = 8,
    parameter int SFR_SPAN = 32,
    parameter int B1_GPR   = 32,
    parameter int SHARED   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [OFS_W-1:0]  core_addr,
    input  logic              core_bank,
    input  logic [DATA_W-1:0] core_wdata,
    input  logic              core_we,
    output logic [DATA_W-1:0] core_rdata,
    output logic              sfr_sel,
    output logic [OFS_W:0]    sfr_addr,
    output logic [DATA_W-1:0] sfr_wdata,
    output logic              sfr_we,
    input  logic [DATA_W-1:0] sfr_rdata
);
    localparam int DEPTH = (2 ** OFS_W - SFR_SPAN) + B1_GPR;
    localparam int IDX_W = $clog2(DEPTH);

    region_e           region;
    logic [IDX_W-1:0]  ram_idx;
    logic [OFS_W:0]    full_addr;
    logic              ram_we;
    logic [DATA_W-1:0] ram_rdata;

    regbank_addr_map #(
        .OFS_W   (OFS_W),
        .SFR_SPAN(SFR_SPAN),
        .B1_GPR  (B1_GPR),
        .SHARED  (SHARED),
        .IDX_W   (IDX_W)
    ) u_map (
        .offset   (core_addr),
        .bank     (core_bank),
        .region   (region),
        .ram_idx  (ram_idx),
        .full_addr(full_addr)
    );

    regbank_gpr_ram #(
        .DEPTH (DEPTH),
        .DATA_W(DATA_W),
        .IDX_W (IDX_W)
    ) u_ram (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (ram_we),
        .idx  (ram_idx),
        .wdata(core_wdata),
        .rdata(ram_rdata)
    );

    always_comb begin
        ram_we     = core_we && (region == RGN_GPR);
        sfr_sel    = (region == RGN_SFR);
        sfr_we     = sfr_sel && core_we;
        sfr_addr   = full_addr;
        sfr_wdata  = core_wdata;
        unique case (region)
            RGN_SFR: core_rdata = sfr_rdata;
            RGN_GPR: core_rdata = ram_rdata;
            default: core_rdata = '0;
        endcase
    end

    p_addr_concat_r1: assert property (@(posedge clk) disable iff (!rst_n)
        sfr_addr == {core_bank, core_addr});

    p_sfr_route_r2: assert property (@(posedge clk) disable iff (!rst_n)
        sfr_sel |-> core_rdata == sfr_rdata);

    p_sfr_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
        sfr_we |-> (sfr_sel && core_we));

    p_hole_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (region == RGN_NONE) |-> (core_rdata == '0 && !sfr_sel));

    p_drop_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (core_we && region != RGN_GPR) |-> !ram_we);

endmodule

// File: tb/sim_regbank_decode.sv
module sim_regbank_decode;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [6:0] core_addr = '0;
    logic       core_bank = 1'b0;
    logic [7:0] core_wdata = '0;
    logic       core_we = 1'b0;
    logic [7:0] core_rdata;
    logic       sfr_sel;
    logic [7:0] sfr_addr;
    logic [7:0] sfr_wdata;
    logic       sfr_we;
    logic [7:0] sfr_rdata = 8'h5A;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    regbank_decode u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .core_addr (core_addr),
        .core_bank (core_bank),
        .core_wdata(core_wdata),
        .core_we   (core_we),
        .core_rdata(core_rdata),
        .sfr_sel   (sfr_sel),
        .sfr_addr  (sfr_addr),
        .sfr_wdata (sfr_wdata),
        .sfr_we    (sfr_we),
        .sfr_rdata (sfr_rdata)
    );

    // {bank, offset, we, wdata, expected read, requirement number}
    localparam int NV = 18;
    localparam logic [28:0] VEC [NV] = '{
        {1'b0, 7'h20, 1'b1, 8'h11, 8'h00, 4'd4},
        {1'b0, 7'h20, 1'b0, 8'h00, 8'h11, 4'd4},
        {1'b0, 7'h7F, 1'b1, 8'h22, 8'h00, 4'd4},
        {1'b0, 7'h7F, 1'b0, 8'h00, 8'h22, 4'd4},
        {1'b1, 7'h20, 1'b1, 8'h33, 8'h00, 4'd5},
        {1'b1, 7'h20, 1'b0, 8'h00, 8'h33, 4'd5},
        {1'b0, 7'h20, 1'b0, 8'h00, 8'h11, 4'd5},
        {1'b1, 7'h3F, 1'b1, 8'h44, 8'h00, 4'd5},
        {1'b1, 7'h3F, 1'b0, 8'h00, 8'h44, 4'd5},
        {1'b1, 7'h70, 1'b1, 8'h55, 8'h00, 4'd6},
        {1'b0, 7'h70, 1'b0, 8'h00, 8'h55, 4'd6},
        {1'b0, 7'h7F, 1'b1, 8'h66, 8'h00, 4'd6},
        {1'b1, 7'h7F, 1'b0, 8'h00, 8'h66, 4'd6},
        {1'b1, 7'h40, 1'b1, 8'h77, 8'h00, 4'd7},
        {1'b1, 7'h40, 1'b0, 8'h00, 8'h00, 4'd7},
        {1'b1, 7'h6F, 1'b0, 8'h00, 8'h00, 4'd7},
        {1'b0, 7'h05, 1'b0, 8'h00, 8'h5A, 4'd2},
        {1'b1, 7'h1F, 1'b0, 8'h00, 8'h5A, 4'd2}
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // change inputs after a falling edge, then sample 1 ns later (1 ns before the rising edge)
    task automatic drive(input logic b, input int a, input logic we, input int d);
        @(negedge clk);
        core_bank  = b;
        core_addr  = 7'(a);
        core_we    = we;
        core_wdata = 8'(d);
        #1;
    endtask

    initial begin
        #800000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R10: cleared after reset
        drive(0, 'h20, 0, 0); check("R10", core_rdata, 8'h00);
        drive(1, 'h20, 0, 0); check("R10", core_rdata, 8'h00);
        drive(0, 'h7F, 0, 0); check("R10", core_rdata, 8'h00);
        drive(1, 'h3F, 0, 0); check("R10", core_rdata, 8'h00);

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i][28], int'(VEC[i][27:21]), VEC[i][20], int'(VEC[i][19:12]));
            if (!VEC[i][20]) begin
                checks++;
                if (core_rdata !== VEC[i][11:4]) begin
                    errors++;
                    $display("FAIL R%0d vector %0d: actual %h expected %h",
                             VEC[i][3:0], i, core_rdata, VEC[i][11:4]);
                end
            end
        end

        // R1: address composition on the SFR port
        drive(1, 'h03, 0, 0);
        check("R1", sfr_addr, 8'h83);
        check("R1 sel", {7'd0, sfr_sel}, 8'h01);
        drive(0, 'h5B, 0, 0);
        check("R1", sfr_addr, 8'h5B);

        // R2: SFR read value follows the external block
        sfr_rdata = 8'hC6;
        drive(0, 'h0A, 0, 0);
        check("R2", core_rdata, 8'hC6);
        drive(0, 'h20, 0, 0);
        check("R2 gpr no sel", {7'd0, sfr_sel}, 8'h00);

        // R3: strobe and no RAM disturbance
        drive(0, 'h00, 1, 'hEE);
        check("R3 we", {7'd0, sfr_we}, 8'h01);
        check("R3 wdata", sfr_wdata, 8'hEE);
        drive(1, 'h10, 1, 'hEE);
        drive(0, 'h21, 1, 'h99);
        check("R3 gpr we", {7'd0, sfr_we}, 8'h00);
        drive(0, 'h20, 0, 0);
        check("R3", core_rdata, 8'h11);
        drive(1, 'h20, 0, 0);
        check("R3", core_rdata, 8'h33);

        // full pattern: every implemented byte gets a value tied to its address
        for (int a = 32; a < 128; a++) drive(0, a, 1, a);
        for (int a = 32; a < 64; a++) drive(1, a, 1, a + 128);
        for (int a = 32; a < 128; a++) begin
            drive(0, a, 0, 0); check("R4", core_rdata, 8'(a));
        end
        for (int a = 32; a < 64; a++) begin
            drive(1, a, 0, 0); check("R5", core_rdata, 8'(a + 128));
        end
        for (int a = 112; a < 128; a++) begin
            drive(1, a, 0, 0); check("R6", core_rdata, 8'(a));
        end
        drive(1, 'h75, 1, 'h3C);
        drive(0, 'h75, 0, 0);
        check("R6", core_rdata, 8'h3C);

        // R7/R8: holes read zero, writes there vanish
        for (int a = 64; a < 112; a++) drive(1, a, 1, 'hFF);
        drive(1, 'h50, 0, 0);
        check("R7", core_rdata, 8'h00);
        check("R7 sel", {7'd0, sfr_sel}, 8'h00);
        for (int a = 32; a < 128; a++) begin
            drive(0, a, 0, 0);
            check("R8", core_rdata, (a == 'h75) ? 8'h3C : 8'(a));
        end
        for (int a = 32; a < 64; a++) begin
            drive(1, a, 0, 0); check("R8", core_rdata, 8'(a + 128));
        end

        // R9: old value before the edge, new value after it
        drive(0, 'h30, 1, 'hC3);
        check("R9 before", core_rdata, 8'h30);
        @(posedge clk);
        #1;
        check("R9 after", core_rdata, 8'hC3);
        drive(0, 'h30, 0, 0);
        check("R9 hold", core_rdata, 8'hC3);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule